// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It takes the pending-request, mask and in-service vectors held elsewhere and answers two questions: should the interrupt output be raised right now, and which line would be handed out. Priority is circular. A programmable rotation base chooses which line sits at level 0, the most urgent level. The other lines follow it in ascending order, wrapping modulo the line count.

A request is only signalled when it outranks everything currently in service. The in-service set is searched with the same rotated order. Two mode flags change which in-service bits take part in that search. Special-mask mode drops in-service bits whose lines are masked, so lower-priority lines can interrupt a masked handler. Special fully nested mode, when the unit is the master of a cascade, drops the in-service bit of the cascade line, so a second request arriving through the slave can still get through. The block is purely combinational and can drive the interrupt pin directly. The registers, the command decoding and the vector formation are all outside it.

Top module: `intpri_resolver`

## Requirements
- R1: Only lines whose request bit is 1 and whose mask bit is 0 are candidates. With no candidate, irq_valid_o is 0.
- R2: Priority level p belongs to line (p + rot_base_i) mod 8, and level 0 is the most urgent. Among the candidates, the one at the lowest level wins.
- R3: When irq_valid_o is 0, irq_line_o reads 0.
- R4: The current level is the lowest rotated level among the effective in-service bits, or 8 when there are none. irq_valid_o is 1 only when the winning request level is strictly below the current level. An equal level does not signal.
- R5: With spec_mask_i at 1, in-service bits whose mask bit is 1 are left out of the current-level search. In-service bits that are not masked still count.
- R6: With spec_nest_i at 1 and is_master_i at 1, in-service bit 2 (the cascade line) is left out of the current-level search.
- R7: With spec_nest_i at 1 and is_master_i at 0, in-service bit 2 counts like any other bit.
- R8: When irq_valid_o is 1, irq_line_o names the winning line, and that line is a candidate.
- R9: The outputs follow the inputs combinationally, with no clock and no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | 8 | Pending request vector, one bit per line |
| mask_i | input | 8 | Mask vector; 1 blocks the line |
| insvc_i | input | 8 | In-service vector |
| rot_base_i | input | 3 | Line placed at priority level 0 |
| spec_mask_i | input | 1 | Special-mask mode enable |
| spec_nest_i | input | 1 | Special fully nested mode enable |
| is_master_i | input | 1 | Unit is the cascade master |
| irq_valid_o | output | 1 | Interrupt should be raised |
| irq_line_o | output | 3 | Winning line number, 0 when idle |

## Verification
The checker evaluates four properties on every input change. A raised output always names a candidate line. No candidate sits at a more urgent rotated level than the winner. No effective in-service bit sits at or above the winner's level. An idle output reads line 0. Those properties cannot show that valid rises in every case where it should, or that the two mode flags apply only under the right conditions. The table of scenarios covers equal-level blocking, masked and unmasked in-service bits under special-mask mode, and the cascade bit with the master flag on and off. A sweep of random patterns is compared against a rotated level search written in the bench.

// File: rtl/intpri_pkg.sv
package intpri_pkg;

   // Implementation choice for the lowest-set-bit encoder
   typedef enum logic {
      ENC_SCAN   = 1'b0,
      ENC_ONEHOT = 1'b1
   } enc_style_e;

   function automatic bit is_pow2(int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/intpri_rotator.sv
// Rotates a vector so that bit p of the result is bit (p + base) mod N of the input.
module intpri_rotator #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  vec_i,
   input  logic [IW-1:0] base_i,
   output logic [N-1:0]  rot_o
);
   logic [2*N-1:0] doubled;
   logic [2*N-1:0] shifted;

   assign doubled = {vec_i, vec_i};
   assign shifted = doubled >> base_i;
   assign rot_o   = shifted[N-1:0];
endmodule

// File: rtl/intpri_lowest.sv
// Index of the lowest set bit; N when the vector is empty.
module intpri_lowest #(
   parameter int unsigned            N     = 8,
   parameter int unsigned            LW    = 4,
   parameter intpri_pkg::enc_style_e STYLE = intpri_pkg::ENC_SCAN
) (
   input  logic [N-1:0]  vec_i,
   output logic [LW-1:0] lvl_o
);
   localparam logic [LW-1:0] NONE = LW'(N);

   generate
      if (STYLE == intpri_pkg::ENC_SCAN) begin : g_scan
         always_comb begin
            lvl_o = NONE;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec_i[i]) lvl_o = LW'(i);
            end
         end
      end else begin : g_onehot
         logic [N-1:0]  iso;
         logic [LW-1:0] enc;
         assign iso = vec_i & (~vec_i + 1'b1);
         always_comb begin
            enc = '0;
            for (int i = 0; i < N; i++) begin
               if (iso[i]) enc = enc | LW'(i);
            end
         end
         assign lvl_o = (vec_i == '0) ? NONE : enc;
      end
   endgenerate
endmodule

// File: rtl/intpri_insvc_filter.sv
// Selects which in-service bits take part in the current-level search.
module intpri_insvc_filter #(
   parameter int unsigned N    = 8,
   parameter int unsigned CASC = 2
) (
   input  logic [N-1:0] insvc_i,
   input  logic [N-1:0] mask_i,
   input  logic         spec_mask_i,
   input  logic         spec_nest_i,
   input  logic         is_master_i,
   output logic [N-1:0] eff_o
);
   localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

   logic [N-1:0] keep_mask;
   logic [N-1:0] keep_casc;

   assign keep_mask = spec_mask_i ? ~mask_i : '1;
   assign keep_casc = (spec_nest_i && is_master_i) ? ~CASC_BIT : '1;
   assign eff_o     = insvc_i & keep_mask & keep_casc;
endmodule

// File: rtl/intpri_resolver.sv
module intpri_resolver #(
   parameter int unsigned            NUM_LINES    = 8,
   parameter int unsigned            CASCADE_LINE = 2,
   parameter intpri_pkg::enc_style_e ENC_STYLE    = intpri_pkg::ENC_SCAN,
   localparam int unsigned           IW           = $clog2(NUM_LINES),
   localparam int unsigned           LW           = IW + 1
) (
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] insvc_i,
   input  logic [IW-1:0]        rot_base_i,
   input  logic                 spec_mask_i,
   input  logic                 spec_nest_i,
   input  logic                 is_master_i,
   output logic                 irq_valid_o,
   output logic [IW-1:0]        irq_line_o
);
   if (!intpri_pkg::is_pow2(NUM_LINES)) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (CASCADE_LINE >= NUM_LINES) begin : g_bad_casc
      $error("CASCADE_LINE must be below NUM_LINES");
   end

   logic [NUM_LINES-1:0] cand;
   logic [NUM_LINES-1:0] cand_rot;
   logic [NUM_LINES-1:0] eff_isr;
   logic [NUM_LINES-1:0] isr_rot;
   logic [LW-1:0]        req_lvl;
   logic [LW-1:0]        cur_lvl;
   logic [IW-1:0]        line_sum;

   assign cand = req_i & ~mask_i;

   intpri_insvc_filter #(.N(NUM_LINES), .CASC(CASCADE_LINE)) u_filt (
      .insvc_i     (insvc_i),
      .mask_i      (mask_i),
      .spec_mask_i (spec_mask_i),
      .spec_nest_i (spec_nest_i),
      .is_master_i (is_master_i),
      .eff_o       (eff_isr)
   );

   intpri_rotator #(.N(NUM_LINES), .IW(IW)) u_rot_req (
      .vec_i (cand), .base_i (rot_base_i), .rot_o (cand_rot)
   );
   intpri_rotator #(.N(NUM_LINES), .IW(IW)) u_rot_isr (
      .vec_i (eff_isr), .base_i (rot_base_i), .rot_o (isr_rot)
   );

   intpri_lowest #(.N(NUM_LINES), .LW(LW), .STYLE(ENC_STYLE)) u_low_req (
      .vec_i (cand_rot), .lvl_o (req_lvl)
   );
   intpri_lowest #(.N(NUM_LINES), .LW(LW), .STYLE(ENC_STYLE)) u_low_isr (
      .vec_i (isr_rot), .lvl_o (cur_lvl)
   );

   // Sum wraps in IW bits, which is mod NUM_LINES for a power of two
   assign line_sum    = req_lvl[IW-1:0] + rot_base_i;
   assign irq_valid_o = (req_lvl < cur_lvl);
   assign irq_line_o  = irq_valid_o ? line_sum : '0;
endmodule

// File: rtl/intpri_resolver_chk.sv
module intpri_resolver_chk #(
   parameter int unsigned NUM_LINES    = 8,
   parameter int unsigned CASCADE_LINE = 2,
   localparam int unsigned IW          = $clog2(NUM_LINES)
) (
   input logic [NUM_LINES-1:0] req_i,
   input logic [NUM_LINES-1:0] mask_i,
   input logic [NUM_LINES-1:0] insvc_i,
   input logic [IW-1:0]        rot_base_i,
   input logic                 spec_mask_i,
   input logic                 spec_nest_i,
   input logic                 is_master_i,
   input logic                 irq_valid_o,
   input logic [IW-1:0]        irq_line_o
);
   logic [NUM_LINES-1:0] c_cand;
   logic [NUM_LINES-1:0] c_isr;
   logic [IW-1:0]        win_lvl;
   logic                 beaten;
   logic                 blocked;

   always_comb begin
      c_cand = req_i & ~mask_i;
      c_isr  = insvc_i;
      if (spec_mask_i) c_isr = c_isr & ~mask_i;
      if (spec_nest_i && is_master_i) c_isr[CASCADE_LINE] = 1'b0;
      win_lvl = irq_line_o - rot_base_i;
      beaten  = 1'b0;
      blocked = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (c_cand[i] && (IW'(i) - rot_base_i) < win_lvl) beaten = 1'b1;
         if (c_isr[i] && (IW'(i) - rot_base_i) <= win_lvl) blocked = 1'b1;
      end
   end

   always_comb begin
      if (irq_valid_o) begin
         assert_win_is_cand_R8: assert (c_cand[irq_line_o]);
         assert_win_is_best_R2: assert (!beaten);
         assert_win_beats_isr_R4: assert (!blocked);
      end else begin
         assert_idle_line_zero_R3: assert (irq_line_o == '0);
      end
   end
endmodule

bind intpri_resolver intpri_resolver_chk #(
   .NUM_LINES    (NUM_LINES),
   .CASCADE_LINE (CASCADE_LINE)
) u_chk (
   .req_i       (req_i),
   .mask_i      (mask_i),
   .insvc_i     (insvc_i),
   .rot_base_i  (rot_base_i),
   .spec_mask_i (spec_mask_i),
   .spec_nest_i (spec_nest_i),
   .is_master_i (is_master_i),
   .irq_valid_o (irq_valid_o),
   .irq_line_o  (irq_line_o)
);

// File: tb/intpri_resolver_test.sv
module intpri_resolver_test;

   typedef struct packed {
      logic [7:0] req;
      logic [7:0] imr;
      logic [7:0] isr;
      logic [2:0] base;
      logic       smm;
      logic       sfn;
      logic       mst;
      logic       ev;
      logic [2:0] el;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd3}, // R3 idle
      '{8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd2}, // R2 single
      '{8'h90, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 4'd2}, // R2 base 0
      '{8'h90, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 4'd2}, // R2 rotated
      '{8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd1}, // R1 all masked
      '{8'h0C, 8'h04, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 4'd1}, // R1 mask skips
      '{8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd4}, // R4 equal level
      '{8'h04, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 4'd4}, // R4 higher wins
      '{8'h20, 8'h00, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd4}, // R4 lower blocked
      '{8'h20, 8'h08, 8'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5, 4'd5}, // R5 masked isr dropped
      '{8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 4'd6}, // R6 cascade dropped
      '{8'h20, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd7}, // R7 slave keeps bit
      '{8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 4'd6}, // R6 re-entry
      '{8'h41, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd2}, // R2 wrap
      '{8'h01, 8'h08, 8'h0A, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 4'd5}, // R5 partial
      '{8'h80, 8'h00, 8'h01, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 4'd4}, // R4 rotated isr
      '{8'h20, 8'h00, 8'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5}  // R5 unmasked kept
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] req, imr, isr;
   logic [2:0] base;
   logic       smm, sfn, mst;
   logic       v_o;
   logic [2:0] l_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   intpri_resolver uut (
      .req_i       (req),
      .mask_i      (imr),
      .insvc_i     (isr),
      .rot_base_i  (base),
      .spec_mask_i (smm),
      .spec_nest_i (sfn),
      .is_master_i (mst),
      .irq_valid_o (v_o),
      .irq_line_o  (l_o)
   );

   function automatic logic [3:0] ref_out(input logic [7:0] rq, im, is,
                                          input logic [2:0] b,
                                          input logic sm, sf, ms);
      logic [7:0] cd, ef;
      int best, cur;
      cd = rq & ~im;
      ef = is;
      if (sm) ef = ef & ~im;
      if (sf && ms) ef[2] = 1'b0;
      best = 8;
      cur  = 8;
      for (int p = 7; p >= 0; p--) begin
         if (cd[(p + b) % 8]) best = p;
         if (ef[(p + b) % 8]) cur = p;
      end
      if (best < cur) return {1'b1, 3'((best + b) % 8)};
      return 4'b0000;
   endfunction

   task automatic check(input string tag, input logic ev, input logic [2:0] el);
      n_chk++;
      if (v_o !== ev || l_o !== el) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                  tag, v_o, l_o, ev, el);
      end
   endtask

   task automatic apply(input logic [7:0] rq, im, is, input logic [2:0] b,
                        input logic sm, sf, ms);
      @(negedge clk);
      req = rq; imr = im; isr = is; base = b; smm = sm; sfn = sf; mst = ms;
      #1;
   endtask

   initial begin
      req = '0; imr = '0; isr = '0; base = '0; smm = 1'b0; sfn = 1'b0; mst = 1'b0;
      repeat (3) @(negedge clk);
      check("R3 reset", 1'b0, 3'd0);
      rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         apply(TBL[k].req, TBL[k].imr, TBL[k].isr, TBL[k].base,
               TBL[k].smm, TBL[k].sfn, TBL[k].mst);
         check($sformatf("R%0d vector %0d", TBL[k].rq, k), TBL[k].ev, TBL[k].el);
      end

      // R2: every base with one line requested reports that line
      for (int b = 0; b < 8; b++) begin
         apply(8'h01 << ((b + 3) % 8), 8'h00, 8'h00, 3'(b), 1'b0, 1'b0, 1'b0);
         check("R2 base sweep", 1'b1, 3'((b + 3) % 8));
      end

      // R9: change mid-cycle, result visible before any clock edge
      @(posedge clk);
      #0.5;
      req = 8'h40; imr = 8'h00; isr = 8'h00; base = 3'd0;
      #0.5;
      check("R9 no clock", 1'b1, 3'd6);

      // R1 R4 R5 R6 R7 R8: random sweep against the rotated search
      for (int k = 0; k < 3000; k++) begin
         logic [3:0] e;
         logic [7:0] a, m, s;
         logic [2:0] b;
         logic [2:0] f;
         a = 8'($urandom); m = 8'($urandom) & 8'($urandom);
         s = 8'($urandom) & 8'($urandom); b = 3'($urandom); f = 3'($urandom);
         apply(a, m, s, b, f[0], f[1], f[2]);
         e = ref_out(a, m, s, b, f[0], f[1], f[2]);
         check("R8 random", e[3], e[2:0]);
      end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule